// File: doc/BRIEF.md
# Machine Cycle Timing Generator

This block sets the machine-cycle rhythm of a small 8-bit processor core. It runs from a tick clock at twice the machine clock rate, so each machine clock period is two ticks. A position counter inside each machine cycle drives two timing strobes: an early strobe near the start of the cycle and a late strobe just before its end. At every cycle boundary the block picks the next cycle type: initialization after reset, then instruction fetch, execute, DMA or interrupt service. Datapath, register file, instruction decoding and memory data timing lie outside it.

Execution can be frozen in two ways. The first is a hardware hold through an active-low wait input, which takes effect only where a strobe has just risen. The second is a software idle command, which freezes at the late strobe until a DMA or interrupt request arrives. While frozen, the strobes, state and phase keep their levels. In idle the memory-read line is also forced inactive and the data bus is released.

Top module: `mcycle_timer`

## Requirements
- R1: While `rst_n` is low, the outputs show state RESET (code 000), both strobes low, `mem_rd_n` high and `bus_float` low, immediately and without a clock edge. The first tick after release enters INIT (code 001) at position 0.
- R2: An INIT cycle lasts 18 ticks (9 machine clocks) and every other cycle lasts 16 ticks (8 machine clocks). The position runs from 0 and `phase_hi` is 1 exactly at even positions, where the machine clock rises.
- R3: `stb_early` is high at positions 2 and 3. `stb_late` is high at the second- and third-last positions of the cycle. The two strobes are never high together.
- R4: At the end of a cycle the next state follows these rules. FETCH (010) always goes to EXEC (011). INIT goes to DMA (100) if `dma_req` is high and to FETCH otherwise. EXEC, DMA and INT (101) go to DMA if `dma_req` is high, else to INT if `int_req` is high, else to FETCH.
- R5: `flag_sample` is high only during the final tick of a FETCH cycle.
- R6: `mem_rd_n` is low in FETCH, EXEC and DMA cycles from position 4 to the end of the cycle, and high in all other cases.
- R7: If `wait_n` is low on a tick that leaves position 2, or on a tick that leaves the late-strobe rising position, the position, state and strobes hold. A low `wait_n` at any other position has no effect.
- R8: After a hold at the early strobe, the first advance lands on an odd position (`phase_hi` 0, a falling machine edge). After a hold at the late strobe, it lands on an even position (`phase_hi` 1, a rising edge).
- R9: `idle_cmd` is sampled on advancing ticks of an EXEC cycle before the late-strobe position. When the cycle reaches that position, the block freezes there with `bus_float` 1 and `mem_rd_n` 1, and all other outputs keep their levels. Raising `wait_n` does not end idle. `idle_cmd` in any other state is ignored.
- R10: A tick with `dma_req` or `int_req` high ends idle and advances the position. The following cycle boundary then applies the R4 priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the machine clock rate |
| rst_n | input | 1 | Asynchronous active-low clear |
| wait_n | input | 1 | Active-low hardware hold request |
| dma_req | input | 1 | DMA cycle request |
| int_req | input | 1 | Interrupt request |
| idle_cmd | input | 1 | Software idle command from the decoder |
| stb_early | output | 1 | Early timing strobe |
| stb_late | output | 1 | Late timing strobe |
| cyc_state | output | 3 | Current cycle type code |
| phase_hi | output | 1 | Machine clock level implied by the tick position |
| mem_rd_n | output | 1 | Active-low memory read level |
| bus_float | output | 1 | Data bus release enable (idle) |
| flag_sample | output | 1 | Pulse marking where flag inputs are sampled |

## Verification
The same request that ends idle also takes part in choosing the next cycle. A wake-up and the R4 priority decision therefore act on one request within a few ticks of each other. The bench first wakes an idle EXEC cycle with an interrupt alone and expects an INT cycle. It then wakes a second idle with DMA and interrupt raised on the same tick and expects a DMA cycle. In both cases it checks that `bus_float` drops on the very next tick and that the position advances on from the late strobe without losing a tick.

// File: rtl/mcycle_timer.sv
`timescale 1ns/1ps
module mcycle_timer #(
  parameter int CYC_CLKS   = 8,
  parameter int INIT_EXTRA = 1,
  parameter int TPOS_EARLY = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_n,
  input  logic       dma_req,
  input  logic       int_req,
  input  logic       idle_cmd,
  output logic       stb_early,
  output logic       stb_late,
  output logic [2:0] cyc_state,
  output logic       phase_hi,
  output logic       mem_rd_n,
  output logic       bus_float,
  output logic       flag_sample
);
  localparam int TW = $clog2(2 * (CYC_CLKS + INIT_EXTRA));
  localparam logic [TW-1:0] EARLY_T = TW'(2 * TPOS_EARLY);
  localparam logic [TW-1:0] RD_T    = TW'(2 * TPOS_EARLY + 2);
  localparam logic [TW-1:0] LAST_N  = TW'(2 * CYC_CLKS - 1);
  localparam logic [TW-1:0] LAST_I  = TW'(2 * (CYC_CLKS + INIT_EXTRA) - 1);

  localparam logic [2:0] S_RST   = 3'd0;
  localparam logic [2:0] S_INIT  = 3'd1;
  localparam logic [2:0] S_FETCH = 3'd2;
  localparam logic [2:0] S_EXEC  = 3'd3;
  localparam logic [2:0] S_DMA   = 3'd4;
  localparam logic [2:0] S_INT   = 3'd5;

  logic [2:0]    st, nxt;
  logic [TW-1:0] pos, last_t, late_t;
  logic          idle_q, idle_pend, hold_hw, go_idle, mem_cyc;

  assign last_t  = (st == S_INIT) ? LAST_I : LAST_N;
  assign late_t  = last_t - TW'(2);
  assign hold_hw = !wait_n && (st != S_RST) &&
                   ((pos == EARLY_T) || ((pos == late_t) && !idle_pend));
  assign go_idle = idle_pend && (pos == late_t);
  assign mem_cyc = (st == S_FETCH) || (st == S_EXEC) || (st == S_DMA);

  always_comb begin
    case (st)
      S_INIT:  nxt = dma_req ? S_DMA : S_FETCH;
      S_FETCH: nxt = S_EXEC;
      default: nxt = dma_req ? S_DMA : (int_req ? S_INT : S_FETCH);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RST;
      pos       <= '0;
      idle_q    <= 1'b0;
      idle_pend <= 1'b0;
    end else if (st == S_RST) begin
      st  <= S_INIT;
      pos <= '0;
    end else if (idle_q) begin
      if (dma_req || int_req) begin
        idle_q <= 1'b0;
        pos    <= pos + 1'b1;
      end
    end else if (go_idle) begin
      idle_q    <= 1'b1;
      idle_pend <= 1'b0;
    end else if (hold_hw) begin
      idle_pend <= idle_pend;
    end else if (pos == last_t) begin
      pos       <= '0;
      st        <= nxt;
      idle_pend <= 1'b0;
    end else begin
      pos <= pos + 1'b1;
      if (st == S_EXEC && idle_cmd && pos < late_t) idle_pend <= 1'b1;
    end
  end

  assign cyc_state   = st;
  assign phase_hi    = ~pos[0];
  assign stb_early   = (st != S_RST) && (pos == EARLY_T || pos == EARLY_T + TW'(1));
  assign stb_late    = (st != S_RST) && (pos == late_t || pos == late_t + TW'(1));
  assign mem_rd_n    = idle_q || !(mem_cyc && pos >= RD_T);
  assign bus_float   = idle_q;
  assign flag_sample = (st == S_FETCH) && (pos == last_t) && !idle_q;

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_early && stb_late));

  // R4
  fetch_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cyc_state) == S_FETCH && cyc_state != S_FETCH) |-> cyc_state == S_EXEC);

  // R4
  dma_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cyc_state) != cyc_state && $past(dma_req) &&
     $past(cyc_state) != S_FETCH && $past(cyc_state) != S_RST) |-> cyc_state == S_DMA);

  // R9
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_float) |-> stb_late && mem_rd_n);

  // R9
  idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_float && !dma_req && !int_req) |=> bus_float && $stable(cyc_state) && $stable(stb_late));

  // R7
  early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n && !bus_float && $rose(stb_early)) |=> stb_early && $stable(phase_hi));
endmodule

// File: tb/mcycle_timer_test.sv
`timescale 1ns/1ps
module mcycle_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, wait_n = 1'b1, dma_req = 1'b0, int_req = 1'b0, idle_cmd = 1'b0;
  logic stb_early, stb_late, phase_hi, mem_rd_n, bus_float, flag_sample;
  logic [2:0] cyc_state;
  int n = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mcycle_timer uut (
    .clk(clk), .rst_n(rst_n), .wait_n(wait_n), .dma_req(dma_req), .int_req(int_req),
    .idle_cmd(idle_cmd), .stb_early(stb_early), .stb_late(stb_late), .cyc_state(cyc_state),
    .phase_hi(phase_hi), .mem_rd_n(mem_rd_n), .bus_float(bus_float), .flag_sample(flag_sample)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    n++;
  endtask

  task automatic step_to(input int target);
    while (n < target) step();
  endtask

  task automatic do_reset(input logic w, input logic d);
    @(negedge clk);
    rst_n = 1'b0; wait_n = w; dma_req = d; int_req = 1'b0; idle_cmd = 1'b0;
    @(negedge clk);
    chk("R1 reset state", cyc_state, 0);
    chk("R1 reset early strobe", stb_early, 0);
    chk("R1 reset late strobe", stb_late, 0);
    chk("R1 reset read level", mem_rd_n, 1);
    chk("R1 reset float", bus_float, 0);
    rst_n = 1'b1;
    n = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // Sweep of undisturbed operation: R1 R2 R3 R4 R5 R6
    do_reset(1'b1, 1'b0);
    for (int k = 1; k <= 18 + 16 * 6; k++) begin
      int p, t, st, last;
      step();
      p = k - 1;
      if (p < 18) begin st = 1; t = p; last = 17; end
      else begin
        t = (p - 18) % 16; last = 15;
        st = (((p - 18) / 16) % 2 == 0) ? 2 : 3;
      end
      chk("R1 R4 state sequence", cyc_state, st);
      chk("R2 phase", phase_hi, (t % 2 == 0) ? 1 : 0);
      chk("R3 early strobe", stb_early, (t == 2 || t == 3) ? 1 : 0);
      chk("R3 late strobe", stb_late, (t == last - 2 || t == last - 1) ? 1 : 0);
      chk("R5 flag sample", flag_sample, (st == 2 && t == last) ? 1 : 0);
      chk("R6 read level", mem_rd_n, (st >= 2 && t >= 4) ? 0 : 1);
    end

    // Next-cycle priority: R4
    do_reset(1'b1, 1'b1);
    begin
      int exp_st [6] = '{4, 5, 2, 3, 4, 5};
      logic set_d [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      logic set_i [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      for (int k = 0; k < 6; k++) begin
        step_to(19 + 16 * k + 1);
        chk("R4 priority choice", cyc_state, exp_st[k]);
        dma_req = set_d[k];
        int_req = set_i[k];
      end
    end

    // Hardware hold and resume phase: R7 R8
    do_reset(1'b0, 1'b0);
    step_to(3);
    chk("R3 early strobe rises", stb_early, 1);
    step_to(12);
    chk("R7 held early strobe", stb_early, 1);
    chk("R7 held phase", phase_hi, 1);
    chk("R7 held state", cyc_state, 1);
    wait_n = 1'b1;
    step_to(13);
    chk("R8 resume on falling edge", phase_hi, 0);
    chk("R8 early strobe second half", stb_early, 1);
    wait_n = 1'b0;
    step_to(20);
    chk("R7 no hold mid cycle early", stb_early, 0);
    chk("R7 no hold mid cycle late", stb_late, 0);
    step_to(24);
    chk("R7 late strobe not yet", stb_late, 0);
    step_to(25);
    chk("R7 late strobe on time", stb_late, 1);
    step_to(30);
    chk("R7 held late strobe", stb_late, 1);
    chk("R7 held late phase", phase_hi, 0);
    chk("R7 held late state", cyc_state, 1);
    wait_n = 1'b1;
    step_to(31);
    chk("R8 resume on rising edge", phase_hi, 1);
    chk("R8 late strobe second half", stb_late, 1);
    step_to(33);
    chk("R8 fetch after released init", cyc_state, 2);

    // Idle entry, stickiness and wake-up: R9 R10
    do_reset(1'b1, 1'b0);
    step_to(20);
    idle_cmd = 1'b1;
    step_to(21);
    idle_cmd = 1'b0;
    step_to(33);
    chk("R9 idle in fetch ignored float", bus_float, 0);
    chk("R9 idle in fetch ignored strobe", stb_late, 1);
    step_to(34);
    chk("R9 fetch runs to end", stb_late, 0);
    chk("R5 flag at fetch end", flag_sample, 1);
    step_to(39);
    idle_cmd = 1'b1;
    step_to(40);
    idle_cmd = 1'b0;
    step_to(48);
    chk("R9 before idle strobe", stb_late, 1);
    chk("R9 before idle float", bus_float, 0);
    chk("R6 exec read low", mem_rd_n, 0);
    step_to(49);
    chk("R9 idle float", bus_float, 1);
    chk("R9 idle read forced", mem_rd_n, 1);
    chk("R9 idle strobe kept", stb_late, 1);
    chk("R9 idle state kept", cyc_state, 3);
    step_to(50);
    wait_n = 1'b0;
    step_to(53);
    wait_n = 1'b1;
    step_to(60);
    chk("R9 wait does not wake float", bus_float, 1);
    chk("R9 wait does not wake strobe", stb_late, 1);
    chk("R9 wait does not wake phase", phase_hi, 0);
    int_req = 1'b1;
    step_to(61);
    chk("R10 interrupt wakes", bus_float, 0);
    chk("R10 wake advances position", stb_late, 1);
    chk("R10 wake advances phase", phase_hi, 1);
    chk("R10 read restored", mem_rd_n, 0);
    step_to(63);
    chk("R10 interrupt cycle follows", cyc_state, 5);
    int_req = 1'b0;
    step_to(99);
    idle_cmd = 1'b1;
    step_to(100);
    idle_cmd = 1'b0;
    step_to(109);
    chk("R9 second idle", bus_float, 1);
    step_to(115);
    dma_req = 1'b1;
    int_req = 1'b1;
    step_to(116);
    chk("R10 joint wake", bus_float, 0);
    step_to(118);
    chk("R10 R4 DMA wins after wake", cyc_state, 4);
    dma_req = 1'b0;
    int_req = 1'b0;

    // Asynchronous clear between edges: R1
    step_to(125);
    chk("R6 DMA read low", mem_rd_n, 0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async state", cyc_state, 0);
    chk("R1 async early", stb_early, 0);
    chk("R1 async late", stb_late, 0);
    chk("R1 async read", mem_rd_n, 1);
    chk("R1 async float", bus_float, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule